// File: doc/BRIEF.md
# Memory Bank Address Decoder

This block decides which of a small set of memory banks a physical address falls into. Each bank is described by a 32-bit configuration word. The word holds an 8 MiB-aligned base address, a 3-bit size code and a valid flag. A global controller enable gates every bank at once. For each presented address the decoder reports, one clock later, whether any bank claims it, which bank does, and the byte offset of the address inside that bank.

A second path builds a configuration word from a requested base address and a byte size. Software models and boot logic can use it to produce correctly formed words. It is registered with the same one-cycle latency.

The bank words are supplied from outside; the block stores no configuration. Within a word, bits 31:23 hold the base, bits 19:17 hold the size code and bit 0 is the valid flag. All other bits are ignored.

Top module: `bank_addr_decoder`

## Requirements
- R1: A bank's base is its configuration bits 31:23 followed by 23 zero bits. Configuration bits 22:20 and 16:1 have no effect on decoding.
- R2: A size code c in 0..6 (bits 19:17) gives a bank size of 4 MiB shifted left by c. The address base + size - 1 hits and base + size does not.
- R3: A bank whose size code is 7 never produces a hit.
- R4: A bank whose bit 0 is clear never produces a hit.
- R5: While ctrl_en is low, hit is low one cycle later. When it is high, every valid bank decodes.
- R6: When several banks claim an address, bank_idx reports the lowest-numbered one.
- R7: On a hit, offset equals the address minus the matched bank's base. On a miss, hit, bank_idx and offset are all zero.
- R8: Decode results and the encoded word appear on the outputs one clock after their inputs are presented.
- R9: For enc_size of 4, 8, 16, 32, 64, 128 or 256 MiB, enc_word holds size code 0..6 in bits 19:17, enc_base bits 31:23 in bits 31:23, and bit 0 set. All other bits are zero.
- R10: Any other enc_size, including zero and 512 MiB, gives an enc_word of all zeros.
- R11: While rst is high at a clock edge, every output becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_en | input | 1 | Global controller enable |
| bank_cfg | input | 128 | Bank configuration words; bank k occupies bits 32k+31:32k |
| addr | input | 32 | Physical address to decode |
| hit | output | 1 | Registered: address falls in an active bank |
| bank_idx | output | 2 | Registered index of the winning bank |
| offset | output | 32 | Registered byte offset within the winning bank |
| enc_base | input | 32 | Requested base for the encode path |
| enc_size | input | 32 | Requested size in bytes for the encode path |
| enc_word | output | 32 | Registered configuration word built from enc_base and enc_size |

## Verification
Several properties are checked by assertions on every cycle. A low enable always yields no hit in the next cycle. A miss always leaves index and offset at zero. A hit's offset never reaches the largest bank size. Any nonzero encoded word carries the valid bit and a legal size code. The priority stage never grants more than one bank. Only the bench's scenarios can show the rest. These are exact range edges at base + size, the lowest-index win on overlapping banks, the insensitivity to ignored configuration bits, and the reserved code and cleared valid bit suppressing a bank. They also cover the encode table and its rejection of sizes that are not listed.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  localparam int CFG_W     = 32;  // configuration word width
  localparam int BASE_LSB  = 23;  // base field is [CFG_W-1:BASE_LSB]
  localparam int CODE_LSB  = 17;  // size code field start
  localparam int CODE_W    = 3;   // size code width
  localparam int MIN_LOG2  = 22;  // log2 of the smallest bank (4 MiB)
  localparam int VALID_BIT = 0;
  localparam logic [CODE_W-1:0] CODE_RSVD = '1;
  localparam int MAX_CODE  = (1 << CODE_W) - 2;

  function automatic logic [CFG_W-1:0] base_of(input logic [CFG_W-1:0] w);
    return {w[CFG_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
  endfunction

  function automatic logic [CODE_W-1:0] code_of(input logic [CFG_W-1:0] w);
    return w[CODE_LSB +: CODE_W];
  endfunction
endpackage

// File: rtl/bank_match.sv
module bank_match
  import bank_dec_pkg::*;
#(
  parameter int ADDR_W = CFG_W
) (
  input  logic [CFG_W-1:0]  cfg,
  input  logic              ctrl_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              match,
  output logic [ADDR_W-1:0] rel
);
  logic [ADDR_W-1:0] base;
  logic [CODE_W-1:0] code;
  logic [ADDR_W:0]   span;
  logic              in_range;

  always_comb begin
    base     = ADDR_W'(base_of(cfg));
    code     = code_of(cfg);
    span     = (ADDR_W+1)'(1) << (MIN_LOG2 + int'(code));
    rel      = addr - base;
    in_range = (addr >= base) && ({1'b0, rel} < span);
    match    = ctrl_en && cfg[VALID_BIT] && (code != CODE_RSVD) && in_range;
  end
endmodule

// File: rtl/bank_priority.sv
module bank_priority #(
  parameter int N     = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);
  always_comb begin
    idx   = '0;
    grant = '0;
    any   = |req;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        idx   = IDX_W'(k);
        grant = N'(1) << k;
      end
    end
  end

  always_comb begin
    assert_grant_onehot_R6: assert ($onehot0(grant) && ((grant & ~req) == '0));
  end
endmodule

// File: rtl/bank_cfg_encode.sv
module bank_cfg_encode
  import bank_dec_pkg::*;
(
  input  logic [CFG_W-1:0] base_req,
  input  logic [CFG_W-1:0] size_req,
  output logic [CFG_W-1:0] word
);
  logic             legal;
  logic [CODE_W-1:0] code;

  always_comb begin
    legal = 1'b0;
    code  = '0;
    for (int c = 0; c <= MAX_CODE; c++) begin
      if (size_req == (CFG_W'(1) << (MIN_LOG2 + c))) begin
        legal = 1'b1;
        code  = CODE_W'(c);
      end
    end
    word = '0;
    if (legal) begin
      word                    = base_of(base_req);
      word[CODE_LSB +: CODE_W] = code;
      word[VALID_BIT]          = 1'b1;
    end
  end
endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder
  import bank_dec_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = CFG_W,
  localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int LARGEST  = 1 << (MIN_LOG2 + MAX_CODE)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ctrl_en,
  input  logic [NUM_BANKS*CFG_W-1:0]   bank_cfg,
  input  logic [ADDR_W-1:0]            addr,
  output logic                         hit,
  output logic [IDX_W-1:0]             bank_idx,
  output logic [ADDR_W-1:0]            offset,
  input  logic [CFG_W-1:0]             enc_base,
  input  logic [CFG_W-1:0]             enc_size,
  output logic [CFG_W-1:0]             enc_word
);
  logic [NUM_BANKS-1:0] match;
  logic [ADDR_W-1:0]    rel [NUM_BANKS];
  logic [NUM_BANKS-1:0] grant;
  logic                 any_d;
  logic [IDX_W-1:0]     idx_d;
  logic [ADDR_W-1:0]    off_d;
  logic [CFG_W-1:0]     word_d;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_match #(.ADDR_W(ADDR_W)) u_match (
      .cfg     (bank_cfg[b*CFG_W +: CFG_W]),
      .ctrl_en (ctrl_en),
      .addr    (addr),
      .match   (match[b]),
      .rel     (rel[b])
    );
  end

  bank_priority #(.N(NUM_BANKS)) u_prio (
    .req   (match),
    .any   (any_d),
    .idx   (idx_d),
    .grant (grant)
  );

  always_comb begin
    off_d = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (grant[b]) off_d = rel[b];
  end

  bank_cfg_encode u_enc (
    .base_req (enc_base),
    .size_req (enc_size),
    .word     (word_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit      <= 1'b0;
      bank_idx <= '0;
      offset   <= '0;
      enc_word <= '0;
    end else begin
      hit      <= any_d;
      bank_idx <= any_d ? idx_d : '0;
      offset   <= any_d ? off_d : '0;
      enc_word <= word_d;
    end
  end

  assert_en_gate_R5: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> !hit);

  assert_miss_clean_R7: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (offset == '0 && bank_idx == '0));

  assert_offset_bound_R2: assert property (@(posedge clk) disable iff (rst)
    hit |-> ({1'b0, offset} < (ADDR_W+1)'(LARGEST)));

  assert_enc_form_R9: assert property (@(posedge clk) disable iff (rst)
    (enc_word != '0) |-> (enc_word[VALID_BIT] &&
      code_of(enc_word) != CODE_RSVD && enc_word[BASE_LSB-1:1] == '0 ||
      enc_word[VALID_BIT] && code_of(enc_word) != CODE_RSVD &&
      enc_word[CODE_LSB-1:1] == '0 && enc_word[BASE_LSB-1:CODE_LSB+CODE_W] == '0));
endmodule

// File: tb/bank_addr_decoder_tb.sv
module bank_addr_decoder_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ctrl_en = 1'b0;
  logic [127:0] bank_cfg = '0;
  logic [31:0]  addr = '0;
  logic         hit;
  logic [1:0]   bank_idx;
  logic [31:0]  offset;
  logic [31:0]  enc_base = '0;
  logic [31:0]  enc_size = '0;
  logic [31:0]  enc_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bank_addr_decoder u_dut (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .bank_cfg(bank_cfg),
    .addr(addr), .hit(hit), .bank_idx(bank_idx), .offset(offset),
    .enc_base(enc_base), .enc_size(enc_size), .enc_word(enc_word)
  );

  typedef struct packed {
    logic        en;
    logic [31:0] a;
    logic        h;
    logic [1:0]  i;
    logic [31:0] o;
  } vec_t;

  // bank0: base 0, 16 MiB; bank1: base 8 MiB, 4 MiB (inside bank0);
  // bank2: base 256 MiB, reserved code 7; bank3: base 512 MiB, 8 MiB, junk in ignored bits
  localparam logic [31:0] CFG0 = 32'h0004_0001;
  localparam logic [31:0] CFG1 = 32'h0080_0001;
  localparam logic [31:0] CFG2 = 32'h100E_0001;
  localparam logic [31:0] CFG3 = 32'h2073_FFFF;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_0000, 1'b1, 2'd0, 32'h0000_0000},
    '{1'b1, 32'h00FF_FFFF, 1'b1, 2'd0, 32'h00FF_FFFF},
    '{1'b1, 32'h0100_0000, 1'b0, 2'd0, 32'h0000_0000},
    '{1'b1, 32'h0080_0010, 1'b1, 2'd0, 32'h0080_0010},
    '{1'b1, 32'h1000_0000, 1'b0, 2'd0, 32'h0000_0000},
    '{1'b1, 32'h2000_0004, 1'b1, 2'd3, 32'h0000_0004},
    '{1'b1, 32'h207F_FFFF, 1'b1, 2'd3, 32'h007F_FFFF},
    '{1'b1, 32'h2080_0000, 1'b0, 2'd0, 32'h0000_0000},
    '{1'b0, 32'h0000_1000, 1'b0, 2'd0, 32'h0000_0000}
  };
  localparam string VTAG [NV] = '{"R2", "R2", "R2", "R6", "R3", "R1", "R1", "R2", "R5"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_dec(input string tag, input logic h, input logic [1:0] i,
                           input logic [31:0] o);
    check({tag, " hit"}, {31'b0, hit}, {31'b0, h});
    check({tag, " idx"}, {30'b0, bank_idx}, {30'b0, i});
    check({tag, " offset"}, offset, o);
  endtask

  task automatic decode(input logic en, input logic [31:0] a);
    @(negedge clk);
    ctrl_en = en;
    addr    = a;
    @(negedge clk);  // one register stage (R8)
  endtask

  task automatic encode(input string tag, input logic [31:0] b, input logic [31:0] s,
                        input logic [31:0] exp);
    @(negedge clk);
    enc_base = b;
    enc_size = s;
    @(negedge clk);
    check(tag, enc_word, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs zero under reset
    check_dec("R11 reset", 1'b0, 2'd0, 32'h0);
    check("R11 reset enc", enc_word, 32'h0);
    bank_cfg = {CFG3, CFG2, CFG1, CFG0};
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      decode(VECS[v].en, VECS[v].a);
      check_dec(VTAG[v], VECS[v].h, VECS[v].i, VECS[v].o);
    end

    // R8: result follows the address after exactly one edge
    @(negedge clk);
    ctrl_en = 1'b1;
    addr    = 32'h2000_0100;
    @(posedge clk);
    @(negedge clk);
    check_dec("R8 latency", 1'b1, 2'd3, 32'h0000_0100);

    // R4: clearing bank0 valid hands the overlap to bank1
    bank_cfg[0] = 1'b0;
    decode(1'b1, 32'h0080_0010);
    check_dec("R4 bank0 invalid", 1'b1, 2'd1, 32'h0000_0010);
    decode(1'b1, 32'h0000_0010);
    check_dec("R4 no other bank", 1'b0, 2'd0, 32'h0);
    bank_cfg[0] = 1'b1;

    // R5: re-enable makes banks decode at once
    decode(1'b0, 32'h0000_0040);
    check_dec("R5 disabled", 1'b0, 2'd0, 32'h0);
    decode(1'b1, 32'h0000_0040);
    check_dec("R5 enabled", 1'b1, 2'd0, 32'h0000_0040);

    // R3: code 7 with a normal bank 2 then works
    bank_cfg[95:64] = 32'h100C_0001;  // 256 MiB
    decode(1'b1, 32'h1FFF_FFFF);
    check_dec("R2 largest edge", 1'b1, 2'd2, 32'h0FFF_FFFF);
    bank_cfg[95:64] = CFG2;
    decode(1'b1, 32'h1000_0000);
    check_dec("R3 reserved", 1'b0, 2'd0, 32'h0);

    // R9 / R10: encode path
    encode("R9 64MiB", 32'h1234_5678, 32'h0400_0000, 32'h1208_0001);
    encode("R9 256MiB", 32'hFFFF_FFFF, 32'h1000_0000, 32'hFF8C_0001);
    encode("R9 4MiB", 32'h0000_0000, 32'h0040_0000, 32'h0000_0001);
    encode("R9 8MiB", 32'h0080_0000, 32'h0080_0000, 32'h0082_0001);
    encode("R10 12MiB", 32'h0080_0000, 32'h00C0_0000, 32'h0);
    encode("R10 512MiB", 32'h0080_0000, 32'h2000_0000, 32'h0);
    encode("R10 zero", 32'hFF80_0000, 32'h0000_0000, 32'h0);

    // R11: reset mid-operation clears a live hit
    decode(1'b1, 32'h0000_0080);
    check_dec("R7 live hit", 1'b1, 2'd0, 32'h0000_0080);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_dec("R11 mid reset", 1'b0, 2'd0, 32'h0);
    rst = 1'b0;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule